// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt sources for one processor and presents them through a small word-addressed register port. The sensing type of each source is fixed when the block is built: a bit set in the build mask makes that source edge-sensitive, and a clear bit makes it level-sensitive. Captured sources accumulate in a status register. An enable register masks them to form the pending set. A vector register names the lowest-numbered pending source, and a single interrupt line goes to the processor.

A two-bit master control register keeps capture and output separate. Bit 1 switches hardware capture on and, while set, locks the status register against software writes. Bit 0 gates the interrupt line. Software takes interrupts by writing a mask to the acknowledge address. It can change enables atomically, one bit set at a time, through the set-enable and clear-enable addresses.

The register port is a single-cycle interface with no back-pressure: every access completes in the cycle it is presented, so the port has no ready signal. Read data is combinational from the current register state.

Top module: `vec_intc`

## Requirements
- R1: After reset, status, enable and master control read zero, pending reads zero, the vector reads 0xFFFFFFFF and `irq_o` is low.
- R2: Word address 0 is status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector and 7 master control. Addresses 3, 4 and 5 are write-only and read as zero.
- R3: While master bit 1 is set, every level-sensitive source (build-mask bit 0) that is high sets its status bit on each clock.
- R4: While master bit 1 is set, an edge-sensitive source (build-mask bit 1) sets its status bit only on a 0-to-1 change against its value on the previous clock. Holding it high does not set the bit again.
- R5: While master bit 1 is clear, sources set no status bits, and a write to address 0 replaces the status register. While master bit 1 is set, writes to address 0 are ignored.
- R6: A write to address 3 clears each status bit whose written bit is 1. A level source that is still high, or an edge that rises in the same cycle, leaves its bit set.
- R7: A write to address 4 ORs the data into enable. A write to address 5 clears the enable bits that are 1 in the data. A write to address 2 replaces enable.
- R8: Pending always equals status AND enable.
- R9: The vector is the index of the lowest set pending bit, or 0xFFFFFFFF when pending is zero.
- R10: `irq_o` is high exactly when master bit 0 is set and pending is non-zero.
- R11: Register writes and source events take effect at the clock edge that samples them, so status, pending, vector and `irq_o` show the result right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Interrupt sources, synchronous to clk |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (zero when no read is strobed) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
An acknowledge write and a hardware capture can land on the same status bit in the same cycle. The bench provokes this in two ways: it acknowledges a level source that is still high, and it raises an edge source in the very clock in which software acknowledges that bit. In both cases the bit must still read set after the edge, so capture takes precedence over the clear. A second collision pairs an enable write to master control with a source that is already high, and the bench judges it by whether the capture lands in that same write cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    REG_STAT   = 3'd0,
    REG_PEND   = 3'd1,
    REG_ENAB   = 3'd2,
    REG_ACK    = 3'd3,
    REG_SETEN  = 3'd4,
    REG_CLREN  = 3'd5,
    REG_VEC    = 3'd6,
    REG_MASTER = 3'd7
  } reg_sel_e;

  localparam int unsigned MST_OUT_BIT = 0;
  localparam int unsigned MST_CAP_BIT = 1;
  localparam int unsigned MST_W       = 2;
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int unsigned N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] hit_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i[i];
      end
      assign hit_o[i] = src_i[i] & ~prev_q;
    end else begin : g_level
      assign hit_o[i] = src_i[i];
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned VEC_W = 32
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    vec_o = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = VEC_W'(i);
    end
  end
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_SRC-1:0]  hit_i,
  output logic [N_SRC-1:0]  status_o,
  output logic [N_SRC-1:0]  enable_o,
  output logic [MST_W-1:0]  master_o
);
  logic [N_SRC-1:0] st_n, en_n;
  logic [MST_W-1:0] ms_n;
  logic [N_SRC-1:0] wbits;

  assign wbits = wdata[N_SRC-1:0];

  always_comb begin
    st_n = status_o;
    en_n = enable_o;
    ms_n = master_o;
    if (wr_en) begin
      case (reg_sel_e'(addr))
        REG_STAT:   if (!master_o[MST_CAP_BIT]) st_n = wbits;
        REG_ENAB:   en_n = wbits;
        REG_ACK:    st_n = status_o & ~wbits;
        REG_SETEN:  en_n = enable_o | wbits;
        REG_CLREN:  en_n = enable_o & ~wbits;
        REG_MASTER: ms_n = wdata[MST_W-1:0];
        default:    ;
      endcase
    end
    if (ms_n[MST_CAP_BIT]) st_n = st_n | hit_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      enable_o <= '0;
      master_o <= '0;
    end else begin
      status_o <= st_n;
      enable_o <= en_n;
      master_o <= ms_n;
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o
);
  localparam int unsigned DATA_W = 32;

  logic [N_SRC-1:0]  hit_w, status_q, enable_q, pend_w;
  logic [MST_W-1:0]  master_q;
  logic [DATA_W-1:0] vec_w;
  logic              wr_en;

  assign wr_en = bus_valid & bus_write;

  intc_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .hit_o(hit_w)
  );

  intc_regfile #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .hit_i(hit_w), .status_o(status_q),
    .enable_o(enable_q), .master_o(master_q)
  );

  assign pend_w = status_q & enable_q;

  intc_prio #(.N_SRC(N_SRC), .VEC_W(DATA_W)) u_prio (
    .pend_i(pend_w), .vec_o(vec_w)
  );

  assign irq_o = master_q[MST_OUT_BIT] & (|pend_w);

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (reg_sel_e'(bus_addr))
        REG_STAT:   bus_rdata = DATA_W'(status_q);
        REG_PEND:   bus_rdata = DATA_W'(pend_w);
        REG_ENAB:   bus_rdata = DATA_W'(enable_q);
        REG_VEC:    bus_rdata = vec_w;
        REG_MASTER: bus_rdata = DATA_W'(master_q);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned N_SRC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [2:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [N_SRC-1:0] status_q,
  input logic [N_SRC-1:0] enable_q,
  input logic [1:0]       master_q,
  input logic [N_SRC-1:0] pend_w,
  input logic [31:0]      vec_w,
  input logic             irq_o
);
  localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  logic wr;
  assign wr = bus_valid && bus_write;

  AST_SETEN_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 3'd4) |=> ((enable_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]))); // R7

  AST_CLREN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 3'd5) |=> ((enable_q & $past(bus_wdata[N_SRC-1:0])) == '0)); // R7

  AST_NO_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q[1] && !wr) |=> $stable(status_q)); // R5

  AST_IRQ_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_w != '1)); // R10

  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_w != '1) |-> (pend_w[vec_w[IW-1:0]] &&
      ((pend_w & ((N_SRC'(1) << vec_w[IW-1:0]) - N_SRC'(1))) == '0))); // R9

  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w == '0) |-> (vec_w == '1)); // R9
endmodule

bind vec_intc intc_checker #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_q(status_q),
  .enable_q(enable_q), .master_q(master_q), .pend_w(pend_w),
  .vec_w(vec_w), .irq_o(irq_o)
);

// File: tb/vec_intc_tb.sv
module vec_intc_tb;
  localparam logic [31:0] EMASK = 32'h0000_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  vec_intc #(.N_SRC(32), .EDGE_MASK(EMASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rchk(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic set_src(logic [31:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rchk("R1 status", 3'd0, 32'h0);
    rchk("R1 pending", 3'd1, 32'h0);
    rchk("R1 enable", 3'd2, 32'h0);
    rchk("R1 vector", 3'd6, 32'hFFFF_FFFF);
    rchk("R1 master", 3'd7, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_sw_status();
    wr(3'd0, 32'h5);
    rchk("R5 sw write status", 3'd0, 32'h5);
    rchk("R8 pending masked", 3'd1, 32'h0);
    rchk("R9 vector none", 3'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable();
    wr(3'd4, 32'h4);
    wr(3'd4, 32'h1);
    rchk("R7 set-enable", 3'd2, 32'h5);
    wr(3'd5, 32'h4);
    rchk("R7 clear-enable", 3'd2, 32'h1);
    wr(3'd2, 32'h6);
    rchk("R7 enable replace", 3'd2, 32'h6);
    rchk("R8 pending and", 3'd1, 32'h4);
    rchk("R9 vector 2", 3'd6, 32'h2);
    chk("R10 irq gated off", {31'b0, irq_o}, 32'h0);
    wr(3'd7, 32'h1);
    chk("R10 irq on", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_ack();
    wr(3'd3, 32'h5);
    rchk("R6 ack clears", 3'd0, 32'h0);
    rchk("R9 vector after ack", 3'd6, 32'hFFFF_FFFF);
    chk("R10 irq after ack", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_lock();
    wr(3'd7, 32'h3);
    wr(3'd0, 32'hF);
    rchk("R5 status locked", 3'd0, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    set_src(32'h8);
    rchk("R3 level capture", 3'd0, 32'h8);
    rchk("R9 vector 3", 3'd6, 32'h3);
    chk("R10 irq level", {31'b0, irq_o}, 32'h1);
    wr(3'd3, 32'h8);
    rchk("R6 level relatch", 3'd0, 32'h8);
    set_src(32'h0);
    rchk("R3 sticky after drop", 3'd0, 32'h8);
    wr(3'd3, 32'h8);
    rchk("R6 level cleared", 3'd0, 32'h0);
  endtask

  task automatic t_edge();
    set_src(32'h200);
    rchk("R4 edge capture", 3'd0, 32'h200);
    rchk("R9 vector 9", 3'd6, 32'h9);
    wr(3'd3, 32'h200);
    rchk("R4 held high no recapture", 3'd0, 32'h0);
    set_src(32'h0);
    set_src(32'h200);
    rchk("R4 second rise", 3'd0, 32'h200);
    wr(3'd3, 32'h200);
    set_src(32'h0);
  endtask

  task automatic t_prio();
    set_src(32'h8010_0000);
    rchk("R9 vector 20", 3'd6, 32'd20);
    set_src(32'h8010_0020);
    rchk("R9 vector 5", 3'd6, 32'd5);
    wr(3'd5, 32'h0000_0020);
    rchk("R9 vector after mask", 3'd6, 32'd20);
    rchk("R8 pending masked bit", 3'd1, 32'h8010_0000);
    wr(3'd4, 32'h0000_0020);
    set_src(32'h0);
    wr(3'd3, 32'hFFFF_FFFF);
    rchk("R9 vector empty", 3'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    @(negedge clk);
    src = 32'h400;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h400;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rchk("R6 edge beats ack", 3'd0, 32'h400);
    set_src(32'h0);
    wr(3'd3, 32'h400);
    rchk("R6 cleared after collide", 3'd0, 32'h0);
  endtask

  task automatic t_capture_off();
    wr(3'd7, 32'h1);
    set_src(32'h0000_1010);
    rchk("R5 no capture when off", 3'd0, 32'h0);
    chk("R5 irq stays low", {31'b0, irq_o}, 32'h0);
    wr(3'd7, 32'h3);
    rchk("R11 capture in write cycle", 3'd0, 32'h10);
    set_src(32'h0);
    wr(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_wo_reads();
    rchk("R2 ack reads zero", 3'd3, 32'h0);
    rchk("R2 set-en reads zero", 3'd4, 32'h0);
    rchk("R2 clr-en reads zero", 3'd5, 32'h0);
    rchk("R2 enable at addr 2", 3'd2, 32'hFFFF_FFFF);
    rchk("R2 master at addr 7", 3'd7, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_status();
    t_enable();
    t_ack();
    t_lock();
    t_level();
    t_edge();
    t_prio();
    t_collide();
    t_capture_off();
    t_wo_reads();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule